// File: doc/BRIEF.md
# Registered Command Buffer with Bypass

This block sits on a registered memory module, between the memory controller and the SDRAM devices. It takes the command group from the controller: the two chip selects, row strobe, column strobe, write enable, clock enable, the bank and row/column address, and the eight byte-lane masks. It then drives that group to the devices.

A run-time mode input chooses between two paths. In register mode every signal is captured on the rising clock edge, so the devices see it one cycle later. In buffer mode the signals pass straight through with no clock stage.

Because register mode adds a cycle, a device CAS latency of three shows up as four at the module edge. The block therefore also carries a read-valid strobe through the same path, so that strobe moves with the commands. It also outputs a latency-adjust bit that tells the read-capture logic which mode is active.

Each byte mask is fanned out to the pair of x4 devices that make up its byte lane. The two check-bit nibbles take their masks from lane 1 (low nibble) and lane 5 (high nibble).

Top module: `cmd_regbuf`

## Requirements
- R1: With `reg_mode` = 1 and reset released, `dev_cs_n`, `dev_ras_n`, `dev_cas_n`, `dev_we_n`, `dev_cke`, `dev_ba` and `dev_addr` equal the values their inputs had at the previous rising edge.
- R2: With `reg_mode` = 0, the same outputs equal their inputs in the same cycle, with no clock stage.
- R3: While `rst_n` = 0 in register mode, the outputs take these values:
  - `dev_cs_n` all ones;
  - `dev_ras_n`, `dev_cas_n` and `dev_we_n` at 1 (NOP);
  - `dev_cke` at 0;
  - address and bank at 0;
  - all masks at 1;
  - `rd_vld_out` at 0.
  In buffer mode, reset has no effect on the outputs.
- R4: `dev_dqm[2*i]` and `dev_dqm[2*i+1]` both carry byte mask `in_dqm[i]`. The mask takes one cycle of delay in register mode and none in buffer mode.
- R5: `chk_dqm[0]` carries mask lane 1 and `chk_dqm[1]` carries mask lane 5, with the same timing as R4.
- R6: `rd_vld_out` equals `rd_vld_in` delayed by one cycle in register mode, and equals it in the same cycle in buffer mode.
- R7: `lat_adj` is 1 in register mode and 0 in buffer mode.
- R8: Cycles with both chip selects high (deselect) are forwarded unchanged under R1/R2. The block does not filter commands.
- R9: The capture register loads on every edge outside reset, whatever the mode. A switch to buffer mode takes effect in the same cycle. A switch to register mode at once shows the inputs of the preceding edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset of the capture register |
| reg_mode | input | 1 | 1 = register mode, 0 = buffer mode |
| in_cs_n | input | 2 | Chip selects from controller, active low |
| in_ras_n | input | 1 | Row strobe from controller |
| in_cas_n | input | 1 | Column strobe from controller |
| in_we_n | input | 1 | Write enable from controller |
| in_cke | input | 1 | Clock enable from controller |
| in_ba | input | 2 | Bank select |
| in_addr | input | 13 | Row/column address |
| in_dqm | input | 8 | Byte-lane masks |
| rd_vld_in | input | 1 | Read-valid strobe timed to the device latency |
| dev_cs_n | output | 2 | Chip selects to devices |
| dev_ras_n | output | 1 | Row strobe to devices |
| dev_cas_n | output | 1 | Column strobe to devices |
| dev_we_n | output | 1 | Write enable to devices |
| dev_cke | output | 1 | Clock enable to devices |
| dev_ba | output | 2 | Bank select to devices |
| dev_addr | output | 13 | Address to devices |
| dev_dqm | output | 16 | Per-device masks, two per lane |
| chk_dqm | output | 2 | Masks for check-bit nibbles (lane 1, lane 5) |
| rd_vld_out | output | 1 | Read-valid aligned to the selected mode |
| lat_adj | output | 1 | Extra latency in cycles (0 or 1) |

## Verification
The assertions assume that `reg_mode` and every command input change only away from the rising edge. They also assume that reset is applied asynchronously before the first edge. Under these assumptions, the sampled inputs of one edge are exactly what the register path shows at the next edge.

The stimulus changes all inputs, including the mode and reset, only on the falling edge. It holds reset until a full edge has passed in each mode.

Register-mode comparisons against the previous edge start only after one edge with reset released. Mode toggles every cycle are included so that the instant switch of the mux is exercised against a register that has kept loading.

// File: rtl/cmd_regbuf.sv
module cmd_regbuf #(
  parameter int ADDR_W       = 13,
  parameter int BANK_W       = 2,
  parameter int CS_W         = 2,
  parameter int LANES        = 8,
  parameter int DEV_PER_LANE = 2,
  parameter int CHK_LANE_LO  = 1,
  parameter int CHK_LANE_HI  = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_mode,
  input  logic [CS_W-1:0]               in_cs_n,
  input  logic                          in_ras_n,
  input  logic                          in_cas_n,
  input  logic                          in_we_n,
  input  logic                          in_cke,
  input  logic [BANK_W-1:0]             in_ba,
  input  logic [ADDR_W-1:0]             in_addr,
  input  logic [LANES-1:0]              in_dqm,
  input  logic                          rd_vld_in,
  output logic [CS_W-1:0]               dev_cs_n,
  output logic                          dev_ras_n,
  output logic                          dev_cas_n,
  output logic                          dev_we_n,
  output logic                          dev_cke,
  output logic [BANK_W-1:0]             dev_ba,
  output logic [ADDR_W-1:0]             dev_addr,
  output logic [LANES*DEV_PER_LANE-1:0] dev_dqm,
  output logic [1:0]                    chk_dqm,
  output logic                          rd_vld_out,
  output logic                          lat_adj
);

  localparam int BUS_W = CS_W + 4 + BANK_W + ADDR_W + LANES + 1;
  localparam logic [BUS_W-1:0] IDLE_BUS =
    {{CS_W{1'b1}}, 3'b111, 1'b0, {BANK_W{1'b0}}, {ADDR_W{1'b0}}, {LANES{1'b1}}, 1'b0};

  logic [BUS_W-1:0] in_bus, q_bus, sel_bus;
  logic [LANES-1:0] msk;

  assign in_bus = {in_cs_n, in_ras_n, in_cas_n, in_we_n, in_cke, in_ba, in_addr, in_dqm, rd_vld_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_bus <= IDLE_BUS;
    else        q_bus <= in_bus;
  end

  assign sel_bus = reg_mode ? q_bus : in_bus;

  assign {dev_cs_n, dev_ras_n, dev_cas_n, dev_we_n, dev_cke, dev_ba, dev_addr, msk, rd_vld_out} = sel_bus;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    for (genvar d = 0; d < DEV_PER_LANE; d++) begin : g_dev
      assign dev_dqm[l*DEV_PER_LANE + d] = msk[l];
    end
  end

  assign chk_dqm = {msk[CHK_LANE_HI], msk[CHK_LANE_LO]};
  assign lat_adj = reg_mode;

endmodule

// File: rtl/cmd_regbuf_chk.sv
module cmd_regbuf_chk #(
  parameter int ADDR_W       = 13,
  parameter int BANK_W       = 2,
  parameter int CS_W         = 2,
  parameter int LANES        = 8,
  parameter int DEV_PER_LANE = 2,
  parameter int CHK_LANE_LO  = 1,
  parameter int CHK_LANE_HI  = 5
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          reg_mode,
  input logic [CS_W-1:0]               in_cs_n,
  input logic                          in_ras_n,
  input logic                          in_cas_n,
  input logic                          in_we_n,
  input logic                          in_cke,
  input logic [BANK_W-1:0]             in_ba,
  input logic [ADDR_W-1:0]             in_addr,
  input logic [LANES-1:0]              in_dqm,
  input logic                          rd_vld_in,
  input logic [CS_W-1:0]               dev_cs_n,
  input logic                          dev_ras_n,
  input logic                          dev_cas_n,
  input logic                          dev_we_n,
  input logic                          dev_cke,
  input logic [BANK_W-1:0]             dev_ba,
  input logic [ADDR_W-1:0]             dev_addr,
  input logic [LANES*DEV_PER_LANE-1:0] dev_dqm,
  input logic [1:0]                    chk_dqm,
  input logic                          rd_vld_out,
  input logic                          lat_adj
);

  localparam int TOP_DEV = LANES*DEV_PER_LANE - 1;

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R1
  reg_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && reg_mode) |->
      {dev_cs_n, dev_ras_n, dev_cas_n, dev_we_n, dev_cke, dev_ba, dev_addr} ==
      $past({in_cs_n, in_ras_n, in_cas_n, in_we_n, in_cke, in_ba, in_addr}));

  // R2
  buf_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_mode |->
      {dev_cs_n, dev_ras_n, dev_cas_n, dev_we_n, dev_cke, dev_ba, dev_addr} ==
      {in_cs_n, in_ras_n, in_cas_n, in_we_n, in_cke, in_ba, in_addr});

  // R3
  always @(posedge clk) begin
    if (!rst_n && reg_mode)
      reset_nop_chk: assert ((&dev_cs_n) && dev_ras_n && dev_cas_n && dev_we_n && !dev_cke
                             && (&dev_dqm) && !rd_vld_out);
  end

  // R4
  mask_fan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && reg_mode) |->
      (dev_dqm[0] == $past(in_dqm[0])) && (dev_dqm[TOP_DEV] == $past(in_dqm[LANES-1])));

  // R5
  chk_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_mode |-> chk_dqm == {in_dqm[CHK_LANE_HI], in_dqm[CHK_LANE_LO]});

  // R6
  rdv_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && reg_mode) |-> rd_vld_out == $past(rd_vld_in));

  // R6
  rdv_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_mode |-> rd_vld_out == rd_vld_in);

  // R9
  mode_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $rose(reg_mode)) |-> dev_addr == $past(in_addr));

endmodule

bind cmd_regbuf cmd_regbuf_chk #(
  .ADDR_W(ADDR_W), .BANK_W(BANK_W), .CS_W(CS_W), .LANES(LANES),
  .DEV_PER_LANE(DEV_PER_LANE), .CHK_LANE_LO(CHK_LANE_LO), .CHK_LANE_HI(CHK_LANE_HI)
) u_chk (.*);

// File: tb/tb_cmd_regbuf.sv
`timescale 1ns/1ps
module tb_cmd_regbuf;
  localparam int VW = 30;
  localparam logic [VW-1:0] IDLE_V = {2'b11, 3'b111, 1'b0, 2'b00, 13'd0, 8'hFF, 1'b0};

  logic clk = 1'b0;
  logic rst_n, reg_mode;
  logic [1:0] in_cs_n;
  logic in_ras_n, in_cas_n, in_we_n, in_cke, rd_vld_in;
  logic [1:0] in_ba;
  logic [12:0] in_addr;
  logic [7:0] in_dqm;
  logic [1:0] dev_cs_n;
  logic dev_ras_n, dev_cas_n, dev_we_n, dev_cke, rd_vld_out, lat_adj;
  logic [1:0] dev_ba;
  logic [12:0] dev_addr;
  logic [15:0] dev_dqm;
  logic [1:0] chk_dqm;

  int checks = 0;
  int errors = 0;
  logic [VW-1:0] cur_v, prev_v;
  logic last_mode;

  always #10 clk = ~clk;

  cmd_regbuf dut (
    .clk(clk), .rst_n(rst_n), .reg_mode(reg_mode),
    .in_cs_n(in_cs_n), .in_ras_n(in_ras_n), .in_cas_n(in_cas_n), .in_we_n(in_we_n),
    .in_cke(in_cke), .in_ba(in_ba), .in_addr(in_addr), .in_dqm(in_dqm), .rd_vld_in(rd_vld_in),
    .dev_cs_n(dev_cs_n), .dev_ras_n(dev_ras_n), .dev_cas_n(dev_cas_n), .dev_we_n(dev_we_n),
    .dev_cke(dev_cke), .dev_ba(dev_ba), .dev_addr(dev_addr), .dev_dqm(dev_dqm),
    .chk_dqm(chk_dqm), .rd_vld_out(rd_vld_out), .lat_adj(lat_adj)
  );

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic mode, input logic rst, input logic [VW-1:0] v);
    logic [VW-1:0] e;
    logic [15:0] edqm;
    string tag;
    @(negedge clk);
    reg_mode = mode;
    rst_n = rst;
    {in_cs_n, in_ras_n, in_cas_n, in_we_n, in_cke, in_ba, in_addr, in_dqm, rd_vld_in} = v;
    cur_v = v;
    @(posedge clk);
    prev_v = rst ? cur_v : IDLE_V;
    #5;
    e = mode ? prev_v : cur_v;
    for (int l = 0; l < 8; l++) begin
      edqm[2*l]   = e[1 + l];
      edqm[2*l+1] = e[1 + l];
    end
    if (!rst && mode)           tag = "R3";
    else if (mode != last_mode) tag = "R9";
    else if (e[29:28] == 2'b11) tag = "R8";
    else if (mode)              tag = "R1";
    else                        tag = "R2";
    cmp(tag, 32'({dev_cs_n, dev_ras_n, dev_cas_n, dev_we_n, dev_cke, dev_ba, dev_addr}), 32'(e[29:9]));
    cmp("R4", 32'(dev_dqm), 32'(edqm));
    cmp("R5", 32'(chk_dqm), 32'({e[1+5], e[1+1]}));
    cmp("R6", 32'(rd_vld_out), 32'(e[0]));
    cmp("R7", 32'(lat_adj), 32'(mode));
    last_mode = mode;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b1; reg_mode = 1'b1; last_mode = 1'b1;
    {in_cs_n, in_ras_n, in_cas_n, in_we_n, in_cke, in_ba, in_addr, in_dqm, rd_vld_in} = '0;
    prev_v = IDLE_V;
    #1 rst_n = 1'b0;
    // R3 reset in register mode
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, VW'($urandom));
    // R3 reset ignored in buffer mode
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, VW'($urandom));
    // R1 register mode random
    for (int i = 0; i < 60; i++) step(1'b1, 1'b1, VW'($urandom));
    // R2 buffer mode random
    for (int i = 0; i < 60; i++) step(1'b0, 1'b1, VW'($urandom));
    // R9 mode toggling every cycle
    for (int i = 0; i < 40; i++) step(i[0], 1'b1, VW'($urandom));
    // R8 deselect cycles forwarded
    for (int i = 0; i < 40; i++) step(i >= 20, 1'b1, {2'b11, 28'($urandom)});
    // R4 R5 walking mask and all-ones mask
    for (int i = 0; i < 16; i++)
      step(i < 8, 1'b1, {21'($urandom), 8'(1 << (i % 8)), 1'($urandom)});
    step(1'b1, 1'b1, {21'd0, 8'hFF, 1'b1});
    step(1'b1, 1'b1, {21'h1FFFFF, 8'h00, 1'b0});
    // R6 read-valid pulses in both modes
    for (int i = 0; i < 12; i++) step(i >= 6, 1'b1, {29'($urandom), i[1]});
    // R3 reset reapplied mid-run, then released
    step(1'b1, 1'b0, VW'($urandom));
    step(1'b1, 1'b1, VW'($urandom));
    step(1'b1, 1'b1, VW'($urandom));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule